// File: doc/BRIEF.md
# Display panel power sequencer

This block switches the three supply-control lines of a flat panel on and off in a safe order. The lines are a logic-supply enable, a high-voltage supply enable and a display-on signal. When the request input goes high, the block raises the logic supply at once. After a programmable gap it raises the high-voltage supply, and after a second gap it raises display-on. When the request goes low, it lowers the lines in the reverse order with their own gaps. Every gap is counted in display frames, taken from a one-cycle frame-start pulse, and lasts the stored 4-bit value plus one frame.

Two small registers hold the settings. The control register holds the two main gaps and three per-line enable bits. The auxiliary register holds the two gaps that border the logic supply. A line whose enable bit is clear stays low, but its step and gap are still taken, so the other lines keep their timing. The block takes a copy of the settings when a sequence starts. Writes made during a sequence therefore apply to the next sequence. While the block is idle, the copy follows the registers. A status level shows how many steps are in effect. A busy flag and a one-cycle done pulse report progress.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, all three supply lines, `busy`, `seqDone` and `seqLevel` are 0. The control register (address 0) reads 16'h0010 and the auxiliary register (address 1) reads 16'h0000.
- R2: Control register layout: [15:12] gap from high-voltage on to display-on, [11:8] gap from display-off to high-voltage off, [6] logic-supply enable, [5] high-voltage enable, [4] display-on enable. Bits 7 and 3:0 read 0 and ignore writes. Auxiliary register layout: [7:4] gap from logic on to high-voltage on, [3:0] gap from high-voltage off to logic off. Bits 15:8 read 0. Reads are combinational on `regAddr`. A write is sampled on a clock edge with `regWrEn` high.
- R3: When `panelOnReq` is high and `seqLevel` is 0, `busy` is high after the next edge. `seqLevel` becomes 1 one edge later, and the logic supply rises with it. The steps then run logic, high-voltage, display-on, taking `seqLevel` to 1, 2 and 3.
- R4: Each gap lasts field+1 frame-start pulses. Only pulses sampled from the second edge after the previous step count. The step happens on the edge that samples the last counted pulse. A field of 0 gives a one-frame gap and 15 gives sixteen frames.
- R5: When `panelOnReq` is low and `seqLevel` is 3, display-on falls one edge after `busy` rises. High-voltage falls after the [11:8] gap, then logic falls after the auxiliary [3:0] gap. `seqLevel` steps 2, 1, 0.
- R6: A line whose enable bit is 0 is held low. `seqLevel` and the timing of the other lines are the same as with all lines enabled.
- R7: `busy` is high from the edge after the request differs from the current end level until the edge after the last step. `seqDone` is high for exactly the one cycle in which `busy` first reads 0 again.
- R8: If `panelOnReq` changes direction during a gap, the gap still runs to its end and no step is taken at its end. The sequence then turns back from the current level, and the next step waits for the gap that belongs to that step in the new direction.
- R9: Register writes made while `busy` is high do not change the running sequence's gaps or enables. While idle, the settings take effect from the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 auxiliary |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the selected register |
| frameStart | input | 1 | One-cycle pulse at the start of each display frame |
| panelOnReq | input | 1 | Requested panel state: 1 on, 0 off |
| logicPwrEn | output | 1 | Logic-supply enable |
| hvPwrEn | output | 1 | High-voltage supply enable |
| dispOn | output | 1 | Display-on signal |
| busy | output | 1 | Sequence in progress |
| seqDone | output | 1 | One-cycle pulse when a sequence ends |
| seqLevel | output | 2 | Number of steps currently in effect (0 to 3) |

## Verification
A request sampled on one edge raises `busy` after that edge. The first immediate step lands one edge later. A gap's step lands on the very edge that samples its last counted frame pulse. `seqDone` follows the final step by one edge. Register read data is valid in the same cycle as the address. An idle write reaches the lines two edges later. The bench drives every input shortly after a rising edge. It advances its behavioural model on the same rising edges and compares every output with the model at the following falling edge. Each of these latencies is therefore checked in the exact cycle it is due, across all gap values from 0 to 15, masked lines, and direction changes in mid-gap.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int GAP_W    = 4;
  localparam int NUM_PINS = 3;
  localparam int LEVEL_W  = $clog2(NUM_PINS + 1);
  localparam int REG_W    = 16;

  typedef struct packed {
    logic [GAP_W-1:0] onGap;      // high-voltage on -> display on
    logic [GAP_W-1:0] offGap;     // display off -> high-voltage off
    logic             enLogic;
    logic             enHv;
    logic             enDisp;
    logic [GAP_W-1:0] auxOnGap;   // logic on -> high-voltage on
    logic [GAP_W-1:0] auxOffGap;  // high-voltage off -> logic off
  } seqCfg_t;

  localparam seqCfg_t CFG_RESET = seqCfg_t'({4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0});

  typedef struct packed {
    logic snapLoad;
    logic cntLoad;
    logic cntDirUp;
    logic cntDec;
    logic stepUp;
    logic stepDown;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STEP = 2'd1,
    SEQ_WAIT = 2'd2
  } seqState_t;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output seqCfg_t          cfg
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RESET;
    end else if (wrEn) begin
      if (!addr) begin
        cfg.onGap   <= wrData[15:12];
        cfg.offGap  <= wrData[11:8];
        cfg.enLogic <= wrData[6];
        cfg.enHv    <= wrData[5];
        cfg.enDisp  <= wrData[4];
      end else begin
        cfg.auxOnGap  <= wrData[7:4];
        cfg.auxOffGap <= wrData[3:0];
      end
    end
  end

  always_comb begin
    if (!addr)
      rdData = {cfg.onGap, cfg.offGap, 1'b0, cfg.enLogic, cfg.enHv, cfg.enDisp, 4'b0000};
    else
      rdData = {8'h00, cfg.auxOnGap, cfg.auxOffGap};
  end

endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               targetOn,
  input  logic               frameStart,
  input  logic [LEVEL_W-1:0] level,
  input  logic               cntZero,
  output seqStrobe_t         strobe,
  output logic               busy,
  output logic               done
);

  localparam logic [LEVEL_W-1:0] TOP_LEVEL = LEVEL_W'(NUM_PINS);

  seqState_t          state, nextState;
  logic               waitDirUp;
  logic [LEVEL_W-1:0] wantLevel;

  assign wantLevel = targetOn ? TOP_LEVEL : '0;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      SEQ_IDLE: begin
        strobe.snapLoad = 1'b1;
        if (wantLevel != level) nextState = SEQ_STEP;
      end
      SEQ_STEP: begin
        if (wantLevel == level) begin
          nextState = SEQ_IDLE;
        end else if (targetOn && level == '0) begin
          strobe.stepUp = 1'b1;
        end else if (!targetOn && level == TOP_LEVEL) begin
          strobe.stepDown = 1'b1;
        end else begin
          strobe.cntLoad  = 1'b1;
          strobe.cntDirUp = targetOn;
          nextState       = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (frameStart) begin
          if (cntZero) begin
            nextState = SEQ_STEP;
            if (waitDirUp && targetOn)        strobe.stepUp   = 1'b1;
            else if (!waitDirUp && !targetOn) strobe.stepDown = 1'b1;
          end else begin
            strobe.cntDec = 1'b1;
          end
        end
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      waitDirUp <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == SEQ_STEP) && (nextState == SEQ_IDLE);
      if (strobe.cntLoad) waitDirUp <= strobe.cntDirUp;
    end
  end

  assign busy = (state != SEQ_IDLE);

endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqCfg_t             cfg,
  input  seqStrobe_t          strobe,
  output logic [LEVEL_W-1:0]  level,
  output logic                cntZero,
  output logic [NUM_PINS-1:0] pinOut
);

  seqCfg_t             snap;
  logic [GAP_W-1:0]    cnt;
  logic [GAP_W-1:0]    gapSel;
  logic [NUM_PINS-1:0] enMask;

  always_comb begin
    if (strobe.cntDirUp)
      gapSel = (level == LEVEL_W'(1)) ? snap.auxOnGap : snap.onGap;
    else
      gapSel = (level == LEVEL_W'(2)) ? snap.offGap : snap.auxOffGap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap  <= CFG_RESET;
      level <= '0;
      cnt   <= '0;
    end else begin
      if (strobe.snapLoad) snap <= cfg;
      if (strobe.stepUp)        level <= level + 1'b1;
      else if (strobe.stepDown) level <= level - 1'b1;
      if (strobe.cntLoad)      cnt <= gapSel;
      else if (strobe.cntDec)  cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign enMask  = {snap.enDisp, snap.enHv, snap.enLogic};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pinOut[p] = enMask[p] & (level > LEVEL_W'(p));
  end

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        frameStart,
  input  logic        panelOnReq,
  output logic        logicPwrEn,
  output logic        hvPwrEn,
  output logic        dispOn,
  output logic        busy,
  output logic        seqDone,
  output logic [1:0]  seqLevel
);

  seqCfg_t             cfg;
  seqStrobe_t          strobe;
  logic [LEVEL_W-1:0]  level;
  logic                cntZero;
  logic [NUM_PINS-1:0] pinOut;

  pps_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .rdData (regRdData),
    .cfg    (cfg)
  );

  pps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .targetOn   (panelOnReq),
    .frameStart (frameStart),
    .level      (level),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .busy       (busy),
    .done       (seqDone)
  );

  pps_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .strobe  (strobe),
    .level   (level),
    .cntZero (cntZero),
    .pinOut  (pinOut)
  );

  assign logicPwrEn = pinOut[0];
  assign hvPwrEn    = pinOut[1];
  assign dispOn     = pinOut[2];
  assign seqLevel   = level;

endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       busy,
  input logic       seqDone,
  input logic [1:0] seqLevel,
  input logic       logicPwrEn,
  input logic       hvPwrEn,
  input logic       dispOn
);

  // Level only moves one step at a time
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqLevel != $past(seqLevel)) |->
      (({1'b0, seqLevel} == {1'b0, $past(seqLevel)} + 3'd1) ||
       ({1'b0, $past(seqLevel)} == {1'b0, seqLevel} + 3'd1)));

  // Steps out of the middle levels are paid for with a frame pulse
  assert_gap_needs_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((seqLevel != $past(seqLevel)) && ($past(seqLevel) != 2'd0) && ($past(seqLevel) != 2'd3))
      |-> $past(frameStart));

  // Idle means the level holds on the next edge
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(seqLevel));

  // Done is a single-cycle pulse seen with busy low
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // Fully off at rest means all lines low
  assert_off_lines_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && seqLevel == 2'd0) |-> (!logicPwrEn && !hvPwrEn && !dispOn));

endmodule

bind panel_pwr_seq pps_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .busy       (busy),
  .seqDone    (seqDone),
  .seqLevel   (seqLevel),
  .logicPwrEn (logicPwrEn),
  .hvPwrEn    (hvPwrEn),
  .dispOn     (dispOn)
);

// File: tb/panel_pwr_seq_test.sv
module panel_pwr_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic        frameStart = 1'b0;
  logic        panelOnReq = 1'b0;
  logic [15:0] regRdData;
  logic        logicPwrEn, hvPwrEn, dispOn, busy, seqDone;
  logic [1:0]  seqLevel;

  always #5 clk = ~clk;   // 100 MHz

  panel_pwr_seq uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameStart(frameStart),
    .panelOnReq(panelOnReq), .logicPwrEn(logicPwrEn), .hvPwrEn(hvPwrEn),
    .dispOn(dispOn), .busy(busy), .seqDone(seqDone), .seqLevel(seqLevel)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase  = "R1";
  int    framePer = 6;
  bit    frameRun = 1'b0;
  bit    started  = 1'b0;

  // ---------------- behavioural reference ----------------
  // live register contents
  int rOn, rOff, rAuxOn, rAuxOff; bit rEnL, rEnH, rEnD;
  // copy used by the running sequence
  int sOn, sOff, sAuxOn, sAuxOff; bit sEnL, sEnH, sEnD;
  int mode;      // 0 resting, 1 deciding, 2 counting frames
  int lvl;       // steps in effect
  int left;      // frames still to count minus one
  bit goingUp;
  bit doneExp;

  task automatic modelReset();
    rOn = 0; rOff = 0; rAuxOn = 0; rAuxOff = 0; rEnL = 0; rEnH = 0; rEnD = 1;
    sOn = 0; sOff = 0; sAuxOn = 0; sAuxOff = 0; sEnL = 0; sEnH = 0; sEnD = 1;
    mode = 0; lvl = 0; left = 0; goingUp = 0; doneExp = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      int goal;
      int nMode, nLvl, nLeft;
      bit nUp, nDone;
      goal = panelOnReq ? 3 : 0;
      nMode = mode; nLvl = lvl; nLeft = left; nUp = goingUp; nDone = 0;
      if (mode == 0) begin
        sOn = rOn; sOff = rOff; sAuxOn = rAuxOn; sAuxOff = rAuxOff;
        sEnL = rEnL; sEnH = rEnH; sEnD = rEnD;
        if (goal != lvl) nMode = 1;
      end else if (mode == 1) begin
        if (goal == lvl) begin
          nMode = 0; nDone = 1;
        end else if (goal > lvl && lvl == 0) begin
          nLvl = 1;
        end else if (goal < lvl && lvl == 3) begin
          nLvl = 2;
        end else begin
          nUp = (goal > lvl);
          if (nUp) nLeft = (lvl == 1) ? sAuxOn : sOn;
          else     nLeft = (lvl == 2) ? sOff : sAuxOff;
          nMode = 2;
        end
      end else begin
        if (frameStart) begin
          if (left == 0) begin
            if (goingUp && goal > lvl)       nLvl = lvl + 1;
            else if (!goingUp && goal < lvl) nLvl = lvl - 1;
            nMode = 1;
          end else begin
            nLeft = left - 1;
          end
        end
      end
      mode = nMode; lvl = nLvl; left = nLeft; goingUp = nUp; doneExp = nDone;
      if (regWrEn) begin
        if (!regAddr) begin
          rOn = regWrData[15:12]; rOff = regWrData[11:8];
          rEnL = regWrData[6]; rEnH = regWrData[5]; rEnD = regWrData[4];
        end else begin
          rAuxOn = regWrData[7:4]; rAuxOff = regWrData[3:0];
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      int rdExp;
      rdExp = regAddr ? ((rAuxOn << 4) | rAuxOff)
                      : ((rOn << 12) | (rOff << 8) | (rEnL << 6) | (rEnH << 5) | (rEnD << 4));
      chk("R2", "regRdData", int'(regRdData), rdExp);
      chk(phase, "logicPwrEn", int'(logicPwrEn), int'(sEnL && lvl >= 1));
      chk(phase, "hvPwrEn",    int'(hvPwrEn),    int'(sEnH && lvl >= 2));
      chk(phase, "dispOn",     int'(dispOn),     int'(sEnD && lvl >= 3));
      chk(phase, "seqLevel",   int'(seqLevel),   lvl);
      chk("R7", "busy",    int'(busy),    int'(mode != 0));
      chk("R7", "seqDone", int'(seqDone), int'(doneExp));
    end
  end

  // ---------------- frame pulses ----------------
  initial begin
    forever begin
      if (frameRun) begin
        repeat (framePer - 1) @(posedge clk);
        #2 frameStart = 1'b1;
        @(posedge clk);
        #2 frameStart = 1'b0;
      end else begin
        @(posedge clk);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic regWrite(bit a, logic [15:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(posedge clk);
    for (int i = 0; i < 5000 && busy; i++) @(posedge clk);
    #2;
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic waitLevel(int v);
    for (int i = 0; i < 5000 && int'(seqLevel) != v; i++) @(posedge clk);
    #2;
  endtask

  task automatic request(bit on);
    @(posedge clk); #2;
    panelOnReq = on;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2 rstN = 1'b1;
    started = 1'b1;

    // R1: reset values of both registers and idle outputs
    #1;
    chk("R1", "control reg after reset", int'(regRdData), 16'h0010);
    regAddr = 1'b1;
    #1;
    chk("R1", "aux reg after reset", int'(regRdData), 0);
    chk("R1", "lines after reset", int'({logicPwrEn, hvPwrEn, dispOn}), 0);
    @(posedge clk); #2 regAddr = 1'b0;

    // R2: reserved bits stay zero
    phase = "R2";
    regWrite(1'b0, 16'hFFFF);
    #1 chk("R2", "control reg all ones", int'(regRdData), 16'hFF70);
    regWrite(1'b1, 16'hFFFF);
    #1 chk("R2", "aux reg all ones", int'(regRdData), 16'h00FF);
    @(posedge clk); #2 regAddr = 1'b0;

    // R3 / R5: full power up and down with distinct gaps
    regWrite(1'b0, 16'h3270);
    regWrite(1'b1, 16'h0021);
    frameRun = 1'b1;
    phase = "R3";
    request(1'b1);
    waitIdle();
    chk("R3", "all lines up", int'({logicPwrEn, hvPwrEn, dispOn}), 7);
    phase = "R5";
    request(1'b0);
    waitIdle();
    chk("R5", "all lines down", int'({logicPwrEn, hvPwrEn, dispOn}), 0);

    // R4: shortest and longest gaps
    phase = "R4";
    regWrite(1'b0, 16'h0070);
    regWrite(1'b1, 16'h0000);
    request(1'b1); waitIdle();
    request(1'b0); waitIdle();
    framePer = 3;
    regWrite(1'b0, 16'hFF70);
    regWrite(1'b1, 16'h00FF);
    request(1'b1); waitIdle();
    request(1'b0); waitIdle();
    framePer = 5;

    // R6: masked lines stay low, timing unchanged
    phase = "R6";
    regWrite(1'b0, 16'h2340);
    regWrite(1'b1, 16'h0012);
    request(1'b1); waitIdle();
    chk("R6", "only logic up", int'({logicPwrEn, hvPwrEn, dispOn}), 4);
    request(1'b0); waitIdle();
    regWrite(1'b0, 16'h2330);
    request(1'b1); waitIdle();
    chk("R6", "logic masked", int'({logicPwrEn, hvPwrEn, dispOn}), 3);
    request(1'b0); waitIdle();

    // R8: direction change during a gap, both ways
    phase = "R8";
    regWrite(1'b0, 16'h4470);
    regWrite(1'b1, 16'h0033);
    request(1'b1);
    waitLevel(2);
    request(1'b0);
    waitIdle();
    chk("R8", "turned back to off", int'(seqLevel), 0);
    request(1'b1); waitIdle();
    request(1'b0);
    waitLevel(2);
    repeat (4) @(posedge clk);
    #2 panelOnReq = 1'b1;
    waitIdle();
    chk("R8", "turned back to on", int'(seqLevel), 3);
    request(1'b0); waitIdle();

    // R9: writes while busy apply only to the next sequence
    phase = "R9";
    regWrite(1'b0, 16'h2270);
    regWrite(1'b1, 16'h0011);
    request(1'b1);
    waitLevel(1);
    regWrite(1'b0, 16'h0000);
    regWrite(1'b1, 16'h0000);
    waitIdle();
    chk("R9", "old enables kept", int'(seqLevel), 3);
    request(1'b0); waitIdle();
    request(1'b1); waitIdle();
    chk("R9", "new enables used", int'({logicPwrEn, hvPwrEn, dispOn}), 0);
    request(1'b0); waitIdle();

    frameRun = 1'b0;
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule